// File: doc/BRIEF.md
# Queued I2S Audio Transmitter

This block plays 16-bit PCM audio out of memory onto an I2S serial link. A host posts buffer descriptors, each a byte start address and a byte length, into a five-slot ring. The block reads half-word samples from the buffer at the head of the ring through a simple read port whose data returns one cycle after the request. It serializes them as interleaved left/right stereo words and reports each finished buffer with a one-cycle completion carrying that buffer's start address. It then moves on to the next queued buffer with no gap.

Playback starts when the ring stops being empty. When the ring runs dry, the block keeps framing the link and sends zero words. In master mode the block drives the bit clock and word select itself. In slave mode it follows an external bit clock and word select and leaves its own clock pins low. In both modes a buffer always begins on a left-channel word.

Top module: `i2s_queue_tx`

## Requirements
- R1: While reset is held, sclk_out is 0, ws_out is 1 in master mode, sd_out is 0, and mem_rd, done_valid and post_full are all 0.
- R2: The ring has five slots and holds at most four pending buffers. A post that would fill the fifth slot is refused: post_full is 1 in the cycle after the post, the refused buffer is never played, and the queue is otherwise unchanged.
- R3: A buffer of L bytes plays floor(L/2) samples, read in order from start address plus 0, 2, 4 and so on, with an odd final byte dropped.
- R4: Buffers play in the order they were posted, without restarting the active one. After a buffer's last sample has been loaded into the serializer, done_valid is 1 for one cycle with done_addr equal to that buffer's start address.
- R5: Framing: ws low means left and ws high means right. Each word is 16 bits, MSB first, and its MSB starts one bit clock after the ws transition. sd and ws change only on the falling bit-clock edge. In master mode the bit-clock period is 2*HALF_DIV clock cycles.
- R6: When no buffer is pending, every word sent is 0x0000 and no memory read is issued.
- R7: Every buffer's first sample is sent on a left-channel word. After an odd-length buffer, one zero right word is sent before the next buffer starts.
- R8: A buffer of 0 or 1 bytes completes, with its done_valid pulse, without sending any sample or reading memory.
- R9: In slave mode, framing follows sclk_in and ws_in, the same framing as R5 applies with zero words when dry, and sclk_out and ws_out stay 0.
- R10: A post in the same cycle as a completion is judged against the read position from before that completion. If the ring was full, the post is refused. If the completion empties the ring, the posted buffer is accepted and played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: follow external clock pins; 0: generate them |
| post_valid | input | 1 | Post a buffer descriptor this cycle |
| post_addr | input | ADDR_W | Byte start address of the posted buffer |
| post_len | input | LEN_W | Length of the posted buffer in bytes |
| post_full | output | 1 | Previous cycle's post was refused, ring full |
| mem_rd | output | 1 | Sample read request |
| mem_addr | output | ADDR_W | Byte address of the requested sample |
| mem_rdata | input | 16 | Sample data, valid the cycle after mem_rd |
| done_valid | output | 1 | Head buffer finished this cycle |
| done_addr | output | ADDR_W | Start address of the finished buffer |
| sclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| ws_out | output | 1 | Generated word select (master mode, else 0) |
| sd_out | output | 1 | Serial audio data |

## Verification
A descriptor post and a buffer completion can fall in the same cycle. The bench provokes this by watching done_valid at the falling clock edge and raising post_valid in that same cycle. It does this once when the completion leaves the ring empty and once when the ring already holds four buffers. It judges the first case by post_full staying low and the new buffer's samples following the old ones. It judges the second case by post_full rising and the completion log and audio stream never showing the refused buffer.

// File: rtl/i2s_queue_pkg.sv
`timescale 1ns/1ps
package i2s_queue_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_desc_ring.sv
`timescale 1ns/1ps
module i2s_desc_ring #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int DEPTH  = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NS_W  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [ADDR_W-1:0] post_addr,
    input  logic [LEN_W-1:0]  post_len,
    input  logic              adv,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [NS_W-1:0]   head_nsamp,
    output logic              post_full,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  put_idx
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][NS_W-1:0]   nsamp;
        logic [IDX_W-1:0]             put;
        logic [IDX_W-1:0]             rd;
        logic                         full;
    } ring_t;

    ring_t q, d;
    logic [IDX_W-1:0] put_next;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
    endfunction

    always_comb begin
        d        = q;
        d.full   = 1'b0;
        put_next = bump(q.put);
        if (post_valid) begin
            if (put_next == q.rd) begin
                d.full = 1'b1;
            end else begin
                d.addr[q.put]  = post_addr;
                d.nsamp[q.put] = post_len[LEN_W-1:1];
                d.put          = put_next;
            end
        end
        if (adv) begin
            d.rd = bump(q.rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_valid = (q.rd != q.put);
    assign head_addr  = q.addr[q.rd];
    assign head_nsamp = q.nsamp[q.rd];
    assign post_full  = q.full;
    assign rd_idx     = q.rd;
    assign put_idx    = q.put;
endmodule

// File: rtl/i2s_play_ctrl.sv
`timescale 1ns/1ps
module i2s_play_ctrl
    import i2s_queue_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    localparam int NS_W  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [NS_W-1:0]   head_nsamp,
    input  logic              bnd,
    input  logic              bnd_ch,
    output sample_t           word,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  sample_t           mem_rdata,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr
);
    typedef struct packed {
        logic [NS_W-1:0] off;
        logic            pend;
        logic            stg_v;
        sample_t         stg;
        logic            started;
    } play_t;

    play_t q, d;
    logic  take_ok;

    always_comb begin
        d          = q;
        word       = '0;
        done_valid = 1'b0;
        mem_rd     = 1'b0;
        take_ok    = (bnd_ch == CH_LEFT) || q.started;
        if (q.pend) begin
            d.stg   = mem_rdata;
            d.stg_v = 1'b1;
            d.pend  = 1'b0;
        end
        if (head_valid && (head_nsamp == '0)) begin
            done_valid = 1'b1;
            d.off      = '0;
            d.started  = 1'b0;
        end else if (head_valid && bnd && q.stg_v && take_ok) begin
            word      = q.stg;
            d.stg_v   = 1'b0;
            d.started = 1'b1;
            if (q.off == head_nsamp) begin
                done_valid = 1'b1;
                d.off      = '0;
                d.started  = 1'b0;
            end
        end else if (head_valid && !q.stg_v && !q.pend && (q.off < head_nsamp)) begin
            mem_rd = 1'b1;
            d.off  = q.off + 1'b1;
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = head_addr + ADDR_W'({q.off, 1'b0});
    assign done_addr = head_addr;
endmodule

// File: rtl/i2s_serial_tx.sv
`timescale 1ns/1ps
module i2s_serial_tx
    import i2s_queue_pkg::*;
#(
    parameter int HALF_DIV = 4,
    localparam int HC_W    = $clog2(HALF_DIV) + 1,
    localparam int BC_W    = $clog2(SAMPLE_W)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    slave_mode,
    input  logic    sclk_in,
    input  logic    ws_in,
    input  sample_t word_in,
    output logic    bnd,
    output logic    bnd_ch,
    output logic    sclk_out,
    output logic    ws_out,
    output logic    sd_out
);
    typedef struct packed {
        logic [HC_W-1:0] hcnt;
        logic            sclk;
        logic            ws;
        logic [BC_W-1:0] bcnt;
        sample_t         sh;
        logic            sd;
        logic [1:0]      s_sclk;
        logic [1:0]      s_ws;
        logic            s_prev;
        logic            ws_last;
    } ser_t;

    localparam ser_t SER_RST = '{
        hcnt:    '0,
        sclk:    1'b0,
        ws:      1'b1,
        bcnt:    BC_W'(SAMPLE_W - 1),
        sh:      '0,
        sd:      1'b0,
        s_sclk:  '0,
        s_ws:    2'b11,
        s_prev:  1'b0,
        ws_last: 1'b1
    };

    ser_t q, d;
    logic fall;

    always_comb begin
        d        = q;
        fall     = 1'b0;
        bnd      = 1'b0;
        bnd_ch   = CH_LEFT;
        d.s_sclk = {q.s_sclk[0], sclk_in};
        d.s_ws   = {q.s_ws[0], ws_in};
        d.s_prev = q.s_sclk[1];
        if (slave_mode) begin
            fall = q.s_prev && !q.s_sclk[1];
            if (fall) begin
                bnd       = (q.s_ws[1] != q.ws_last);
                bnd_ch    = q.s_ws[1];
                d.ws_last = q.s_ws[1];
            end
        end else begin
            if (q.hcnt == HC_W'(HALF_DIV - 1)) begin
                d.hcnt = '0;
                d.sclk = !q.sclk;
                if (q.sclk) begin
                    fall   = 1'b1;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == BC_W'(SAMPLE_W - 1)) begin
                        bnd    = 1'b1;
                        d.ws   = !q.ws;
                        bnd_ch = !q.ws;
                    end
                end
            end else begin
                d.hcnt = q.hcnt + 1'b1;
            end
        end
        if (fall) begin
            d.sd = q.sh[SAMPLE_W-1];
            d.sh = bnd ? word_in : (q.sh << 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SER_RST;
        end else begin
            q <= d;
        end
    end

    assign sclk_out = slave_mode ? 1'b0 : q.sclk;
    assign ws_out   = slave_mode ? 1'b0 : q.ws;
    assign sd_out   = q.sd;
endmodule

// File: rtl/i2s_queue_tx.sv
`timescale 1ns/1ps
module i2s_queue_tx
    import i2s_queue_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 12,
    parameter int DEPTH    = 5,
    parameter int HALF_DIV = 4,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int NS_W    = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              post_valid,
    input  logic [ADDR_W-1:0] post_addr,
    input  logic [LEN_W-1:0]  post_len,
    output logic              post_full,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    input  logic              sclk_in,
    input  logic              ws_in,
    output logic              sclk_out,
    output logic              ws_out,
    output logic              sd_out
);
    logic              head_valid;
    logic [ADDR_W-1:0] head_addr;
    logic [NS_W-1:0]   head_nsamp;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  put_idx;
    logic              bnd;
    logic              bnd_ch;
    sample_t           word;

    i2s_desc_ring #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_addr  (post_addr),
        .post_len   (post_len),
        .adv        (done_valid),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_nsamp (head_nsamp),
        .post_full  (post_full),
        .rd_idx     (rd_idx),
        .put_idx    (put_idx)
    );

    i2s_play_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_play (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_nsamp (head_nsamp),
        .bnd        (bnd),
        .bnd_ch     (bnd_ch),
        .word       (word),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .done_valid (done_valid),
        .done_addr  (done_addr)
    );

    i2s_serial_tx #(.HALF_DIV(HALF_DIV)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .sclk_in    (sclk_in),
        .ws_in      (ws_in),
        .word_in    (word),
        .bnd        (bnd),
        .bnd_ch     (bnd_ch),
        .sclk_out   (sclk_out),
        .ws_out     (ws_out),
        .sd_out     (sd_out)
    );
endmodule

// File: rtl/i2s_queue_tx_checker.sv
`timescale 1ns/1ps
module i2s_queue_tx_checker #(
    parameter int DEPTH = 5,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slave_mode,
    input logic             post_valid,
    input logic             post_full,
    input logic             mem_rd,
    input logic             done_valid,
    input logic             sclk_out,
    input logic             ws_out,
    input logic             sd_out,
    input logic [IDX_W-1:0] rd_idx,
    input logic [IDX_W-1:0] put_idx
);
    AST_FULL_NEEDS_POST: assert property (@(posedge clk) disable iff (!rst_n)
        post_full |-> $past(post_valid)); // R2
    AST_FULL_KEEPS_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        post_full |-> (put_idx == $past(put_idx))); // R2
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx < IDX_W'(DEPTH)) && (put_idx < IDX_W'(DEPTH))); // R2
    AST_DONE_MOVES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (rd_idx != $past(rd_idx))); // R4
    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !$past(slave_mode) && !$stable(sd_out)) |-> $fell(sclk_out)); // R5
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !$past(slave_mode) && !$stable(ws_out)) |-> $fell(sclk_out)); // R5
    AST_NO_READ_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == put_idx) |-> !mem_rd); // R6
    AST_SLAVE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!sclk_out && !ws_out)); // R9
endmodule

bind i2s_queue_tx i2s_queue_tx_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .post_valid (post_valid),
    .post_full  (post_full),
    .mem_rd     (mem_rd),
    .done_valid (done_valid),
    .sclk_out   (sclk_out),
    .ws_out     (ws_out),
    .sd_out     (sd_out),
    .rd_idx     (rd_idx),
    .put_idx    (put_idx)
);

// File: tb/i2s_queue_tx_bench.sv
`timescale 1ns/1ps
module i2s_queue_tx_bench;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int HALF   = 4;

    typedef struct packed {
        logic [15:0] a;
        logic [11:0] l;
        logic        f;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'h0100, 12'd8, 1'b0},
        '{16'h0200, 12'd9, 1'b0},
        '{16'h0300, 12'd4, 1'b0},
        '{16'h0400, 12'd4, 1'b0},
        '{16'h0500, 12'd4, 1'b1},
        '{16'h0580, 12'd6, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic post_valid = 1'b0;
    logic [ADDR_W-1:0] post_addr = '0;
    logic [LEN_W-1:0] post_len = '0;
    logic post_full, mem_rd, done_valid, sclk_out, ws_out, sd_out;
    logic [ADDR_W-1:0] mem_addr, done_addr;
    logic [15:0] mem_rdata;
    logic tb_sclk = 1'b0;
    logic tb_ws = 1'b1;
    logic slave_run = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    i2s_queue_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HALF_DIV(HALF)) u_i2s_queue_tx (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .post_valid(post_valid), .post_addr(post_addr), .post_len(post_len),
        .post_full(post_full), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done_valid(done_valid), .done_addr(done_addr),
        .sclk_in(tb_sclk), .ws_in(tb_ws), .sclk_out(sclk_out), .ws_out(ws_out),
        .sd_out(sd_out)
    );

    function automatic logic [15:0] pat(input logic [15:0] a);
        return a ^ 16'hC35A;
    endfunction

    always_ff @(posedge clk) mem_rdata <= mem_rd ? pat(mem_addr) : 16'h0000;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial receiver: decodes words at rising bit-clock edges
    logic [15:0] rx_w [0:511];
    logic        rx_c [0:511];
    int          rx_n = 0;
    bit          rx_first = 1'b1;
    logic        rx_pws = 1'b1;
    logic [15:0] rx_acc = '0;
    wire rx_sclk = slave_mode ? tb_sclk : sclk_out;
    wire rx_ws   = slave_mode ? tb_ws : ws_out;

    always @(posedge rx_sclk) begin
        #1;
        if (rx_ws != rx_pws) begin
            if (!rx_first && rx_n < 512) begin
                rx_w[rx_n] = {rx_acc[14:0], sd_out};
                rx_c[rx_n] = rx_pws;
                rx_n++;
            end
            rx_first = 1'b0;
            rx_acc   = '0;
            rx_pws   = rx_ws;
        end else begin
            rx_acc = {rx_acc[14:0], sd_out};
        end
    end

    logic [15:0] done_log [0:63];
    int done_n = 0;
    always @(negedge clk) begin
        if (rst_n && done_valid && done_n < 64) begin
            done_log[done_n] = done_addr;
            done_n++;
        end
    end

    // external clock source for slave mode
    int fcnt = 0;
    initial begin
        forever begin
            repeat (5) @(posedge clk);
            #1;
            if (slave_run) begin
                if (tb_sclk) begin
                    fcnt++;
                    if (fcnt == 16) begin
                        fcnt  = 0;
                        tb_ws = ~tb_ws;
                    end
                end
                tb_sclk = ~tb_sclk;
            end
        end
    end

    logic [15:0] exp_w [0:31];
    int exp_n = 0;

    task automatic exp_add(input logic [15:0] a, input int ns);
        for (int i = 0; i < ns; i++) begin
            exp_w[exp_n] = pat(a + 16'(2 * i));
            exp_n++;
        end
    endtask

    task automatic check_stream(input string req);
        int k = 0;
        int bad = 0;
        for (int i = 0; i < rx_n; i++) begin
            if (rx_w[i] != 16'h0000) begin
                if (k >= exp_n || rx_w[i] != exp_w[k]) bad++;
                k++;
            end
        end
        chk(bad == 0 && k == exp_n, req, k - bad, exp_n);
    endtask

    task automatic check_left(input logic [15:0] v, input string req);
        int ch = -1;
        for (int i = rx_n - 1; i >= 0; i--) begin
            if (rx_w[i] == v) ch = int'(rx_c[i]);
        end
        chk(ch == 0, req, ch, 0);
    endtask

    task automatic check_tail(input string req);
        int last = -1;
        for (int i = 0; i < rx_n; i++) if (rx_w[i] != 16'h0000) last = i;
        chk(rx_n - 1 - last >= 4, req, rx_n - 1 - last, 4);
    endtask

    task automatic do_reset(input bit sm);
        rst_n      = 1'b0;
        slave_run  = 1'b0;
        slave_mode = sm;
        post_valid = 1'b0;
        repeat (4) @(posedge clk);
        rx_n = 0; rx_first = 1'b1; rx_acc = '0; rx_pws = sm ? tb_ws : 1'b1;
        done_n = 0; exp_n = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic post(input logic [15:0] a, input logic [11:0] l, output bit full);
        @(negedge clk);
        post_valid = 1'b1; post_addr = a; post_len = l;
        @(negedge clk);
        post_valid = 1'b0;
        full = post_full;
    endtask

    task automatic wait_done(input int n, input string req);
        int t = 0;
        while (done_n < n && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(done_n >= n, req, done_n, n);
    endtask

    task automatic wait_done_edge();
        int t = 0;
        @(negedge clk);
        while (!done_valid && t < 30000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog R4 actual=%0d expected=%0d", done_n, 0);
        finish_run();
    end

    initial begin
        bit full;
        realtime t0, t1;

        // reset state, master mode
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sclk_out == 1'b0, "R1 sclk_out", int'(sclk_out), 0);
        chk(ws_out == 1'b1, "R1 ws_out", int'(ws_out), 1);
        chk(sd_out == 1'b0, "R1 sd_out", int'(sd_out), 0);
        chk(mem_rd == 1'b0, "R1 mem_rd", int'(mem_rd), 0);
        chk(done_valid == 1'b0, "R1 done_valid", int'(done_valid), 0);
        chk(post_full == 1'b0, "R1 post_full", int'(post_full), 0);

        // phase A: vector table of posts, ring fill and refusal
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) begin
            post(VEC[i].a, VEC[i].l, full);
            chk(full == VEC[i].f, "R2 post refusal", int'(full), int'(VEC[i].f));
        end
        @(posedge sclk_out); t0 = $realtime;
        @(posedge sclk_out); t1 = $realtime;
        chk(int'(t1 - t0) == 2 * HALF * 5, "R5 bit clock period", int'(t1 - t0), 2 * HALF * 5);
        wait_done(4, "R4 all done");
        repeat (1600) @(negedge clk);
        chk(done_n == 4, "R2 refused never played", done_n, 4);
        chk(done_log[0] == 16'h0100, "R4 done order 0", int'(done_log[0]), 16'h0100);
        chk(done_log[1] == 16'h0200, "R4 done order 1", int'(done_log[1]), 16'h0200);
        chk(done_log[2] == 16'h0300, "R4 done order 2", int'(done_log[2]), 16'h0300);
        chk(done_log[3] == 16'h0400, "R4 done order 3", int'(done_log[3]), 16'h0400);
        exp_add(16'h0100, 4); exp_add(16'h0200, 4); exp_add(16'h0300, 2); exp_add(16'h0400, 2);
        check_stream("R3 R5 sample stream");
        check_left(pat(16'h0100), "R7 first buffer on left");
        check_tail("R6 zero fill after dry");

        // phase B: odd length and zero length buffers
        do_reset(1'b0);
        post(16'h0600, 12'd6, full);
        post(16'h0700, 12'd1, full);
        post(16'h0800, 12'd4, full);
        wait_done(3, "R8 done count");
        repeat (800) @(negedge clk);
        chk(done_log[1] == 16'h0700, "R8 empty buffer done", int'(done_log[1]), 16'h0700);
        exp_add(16'h0600, 3); exp_add(16'h0800, 2);
        check_stream("R8 no samples from empty buffer");
        check_left(pat(16'h0604), "R7 odd tail on left");
        check_left(pat(16'h0800), "R7 next buffer on left");

        // phase C: post colliding with completion
        do_reset(1'b0);
        post(16'h0900, 12'd4, full);
        wait_done_edge();
        post_valid = 1'b1; post_addr = 16'h0A00; post_len = 12'd4;
        @(negedge clk);
        post_valid = 1'b0;
        chk(post_full == 1'b0, "R10 post with emptying completion", int'(post_full), 0);
        wait_done(2, "R10 collided buffer done");
        post(16'h0B00, 12'd4, full);
        post(16'h0C00, 12'd4, full);
        post(16'h0D00, 12'd4, full);
        post(16'h0E00, 12'd4, full);
        wait_done_edge();
        post_valid = 1'b1; post_addr = 16'h0F00; post_len = 12'd4;
        @(negedge clk);
        post_valid = 1'b0;
        chk(post_full == 1'b1, "R10 post with completion while full", int'(post_full), 1);
        wait_done(6, "R10 remaining done");
        repeat (1600) @(negedge clk);
        chk(done_n == 6, "R10 refused buffer absent", done_n, 6);
        chk(done_log[1] == 16'h0A00, "R10 collided order", int'(done_log[1]), 16'h0A00);
        exp_add(16'h0900, 2); exp_add(16'h0A00, 2); exp_add(16'h0B00, 2);
        exp_add(16'h0C00, 2); exp_add(16'h0D00, 2); exp_add(16'h0E00, 2);
        check_stream("R10 stream");

        // phase D: slave mode with external clocks
        do_reset(1'b1);
        slave_run = 1'b1;
        repeat (1300) @(negedge clk);
        chk(sclk_out == 1'b0 && ws_out == 1'b0, "R9 clock pins low", int'({sclk_out, ws_out}), 0);
        chk(rx_n >= 4, "R9 slave words framed", rx_n, 4);
        check_stream("R6 slave zero feed");
        post(16'h1000, 12'd8, full);
        wait_done(1, "R9 slave done");
        repeat (2000) @(negedge clk);
        chk(done_log[0] == 16'h1000, "R9 slave done addr", int'(done_log[0]), 16'h1000);
        exp_add(16'h1000, 4);
        check_stream("R9 slave stream");
        check_left(pat(16'h1000), "R7 slave buffer on left");
        check_tail("R6 slave zero after dry");

        finish_run();
    end
endmodule